// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs the external bus of a small processor core. A requester presents an access (a space code, a direction, an address and, for writes, data) and holds it until the block pulses `done`. The block then drives a low-active select for the addressed space, one of two low-active strobes and the read/write line. The strobes stay low for one base cycle plus the wait states programmed for that space. When enough wait states are programmed, the access can be stretched further by a slow device that holds the ready input low.

Each space has its own 3-bit wait-state count, written through a small configuration port. When two or more wait states are programmed, a low-active indication marks the last programmed wait cycle. If that indication is wired back to the ready input, it forces exactly one extra cycle.

Between accesses, an external master may take the bus with a hold request. The block does not drive the pads directly. It reports drive enables to the pad ring: `bus_oe` covers the address, selects, strobes and read/write line, `data_oe` covers the write data, and `misc_oe` covers the hold acknowledge and the last-wait indication. A global output-disable input removes all of these enables.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: Space codes are 0 program, 1 data, 2 and 3 I/O. The select for the addressed space is low, and the captured address is on `ext_addr`, in exactly the cycles in which a strobe is low. All three selects are high otherwise, and at most one is ever low.
- R2: `mem_stb_n` is low only during program or data accesses, and `io_stb_n` only during I/O accesses. Both are high when idle and never low together.
- R3: `rw_n` is high except during the strobe cycles of a write. During those cycles `ext_dout` carries the write data and `data_oe` is high.
- R4: With a count of W and no ready stretching, an access keeps a strobe low for exactly 1+W cycles. `done` is high for the single cycle that follows. For reads, `rdata` holds the value `ext_din` had in the last strobe cycle.
- R5: The per-space wait-state counts reset to 7. A write with `cfg_we` high loads `cfg_ws` into the count of the space named by `cfg_space`, using the R1 encoding. Accesses accepted afterwards use the new count.
- R6: When the count is 0 or 1, `ext_ready` has no effect on the length of the access.
- R7: When the count is 2 or more, `ext_ready` is first sampled at the clock edge that ends the last programmed wait cycle. Each time it is sampled low, the access gains one cycle and `ext_ready` is sampled again.
- R8: `ws_last_n` is low exactly in the last programmed wait cycle, and only when the count is 2 or more. Fed back into `ext_ready`, it lengthens the access by exactly one cycle.
- R9: A hold request is granted only from idle, never during an access, and takes priority over a pending request. While the hold is granted, `hold_ack_n` is low and `bus_oe` is low, and no access starts. One cycle after the request is withdrawn, both are high again.
- R10: When `out_en_n` is low, `bus_oe`, `data_oe` and `misc_oe` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request, held until `done` |
| req_space | input | 2 | Space code of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| cfg_we | input | 1 | Wait-state count write enable |
| cfg_space | input | 2 | Space whose count is written |
| cfg_ws | input | 3 | New wait-state count |
| sel_prog_n | output | 1 | Program space select, active low |
| sel_data_n | output | 1 | Data space select, active low |
| sel_io_n | output | 1 | I/O space select, active low |
| mem_stb_n | output | 1 | Memory strobe, active low |
| io_stb_n | output | 1 | I/O strobe, active low |
| rw_n | output | 1 | High read, low write |
| ext_addr | output | 16 | Address to the pads |
| ext_dout | output | 16 | Write data to the pads |
| ext_din | input | 16 | Read data from the pads |
| data_oe | output | 1 | Drive enable for `ext_dout` |
| ext_ready | input | 1 | External device ready |
| ws_last_n | output | 1 | Last programmed wait cycle, active low |
| hold_req | input | 1 | Bus hold request |
| hold_ack_n | output | 1 | Hold granted, active low |
| out_en_n | input | 1 | Global output disable, active low |
| bus_oe | output | 1 | Drive enable for address, selects, strobes, read/write |
| misc_oe | output | 1 | Drive enable for `hold_ack_n` and `ws_last_n` |

## Verification
The bench targets the boundary between one and two wait states. A design that samples ready when only one wait state is programmed stretches accesses that should end early. A design that samples ready one edge too early or too late makes the last-wait feedback add zero or two cycles instead of one. The bench also raises a hold request in the middle of a long access. A design that grants it at once drops `bus_oe` while a strobe is still low. Finally, the bench changes the counts per space and uses space code 3. A shared count, or a decode that leaves code 3 unmapped, shows up as wrong strobe lengths or a missing select.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BASE  = 3'd1,
        ST_SWAIT = 3'd2,
        ST_XWAIT = 3'd3,
        ST_HOLD  = 3'd4
    } xbus_st_e;

    localparam int NUM_SPACES = 3;

    // Space code to index: 0 program, 1 data, 2 and 3 I/O
    function automatic logic [1:0] space_idx(input logic [1:0] code);
        return code[1] ? 2'd2 : {1'b0, code[0]};
    endfunction

endpackage

// File: rtl/xbus_wscfg.sv
module xbus_wscfg
    import xbus_pkg::*;
#(
    parameter int WSW    = 3,
    parameter int WS_RST = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_space,
    input  logic [WSW-1:0] cfg_ws,
    input  logic [1:0]     lk_space,
    output logic [WSW-1:0] lk_ws
);
    logic [WSW-1:0] ws_d [NUM_SPACES];
    logic [WSW-1:0] ws_q [NUM_SPACES];

    for (genvar g = 0; g < NUM_SPACES; g++) begin : g_space
        always_comb begin
            ws_d[g] = ws_q[g];
            if (cfg_we && (space_idx(cfg_space) == 2'(g)))
                ws_d[g] = cfg_ws;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ws_q[g] <= WSW'(WS_RST);
            else        ws_q[g] <= ws_d[g];
        end
    end

    always_comb begin
        case (space_idx(lk_space))
            2'd0:    lk_ws = ws_q[0];
            2'd1:    lk_ws = ws_q[1];
            default: lk_ws = ws_q[2];
        endcase
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int WSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_space,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic [WSW-1:0] req_ws,
    input  logic           ext_ready,
    input  logic           hold_req,
    input  logic [DW-1:0]  ext_din,
    output logic           act_o,
    output logic [1:0]     sp_o,
    output logic           wr_o,
    output logic [AW-1:0]  addr_o,
    output logic [DW-1:0]  wdata_o,
    output logic           last_ws_o,
    output logic           hold_o,
    output logic           done_o,
    output logic [DW-1:0]  rdata_o
);
    localparam logic [WSW-1:0] RDY_MIN = WSW'(2);
    localparam logic [WSW-1:0] ONE     = WSW'(1);

    typedef struct packed {
        xbus_st_e       st;
        logic [WSW-1:0] cnt;
        logic           rdy_en;
        logic [1:0]     sp;
        logic           wr;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic           done;
        logic [DW-1:0]  rdata;
    } seq_s;

    seq_s seq_d, seq_q;
    logic fin;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        fin        = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (hold_req) begin
                    seq_d.st = ST_HOLD;
                end else if (req_valid) begin
                    seq_d.st     = ST_BASE;
                    seq_d.cnt    = req_ws;
                    seq_d.rdy_en = (req_ws >= RDY_MIN);
                    seq_d.sp     = space_idx(req_space);
                    seq_d.wr     = req_write;
                    seq_d.addr   = req_addr;
                    seq_d.wdata  = req_wdata;
                end
            end
            ST_BASE: begin
                if (seq_q.cnt == '0) fin = 1'b1;
                else                 seq_d.st = ST_SWAIT;
            end
            ST_SWAIT: begin
                if (seq_q.cnt == ONE) begin
                    if (seq_q.rdy_en && !ext_ready) seq_d.st = ST_XWAIT;
                    else                            fin = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - ONE;
                end
            end
            ST_XWAIT: begin
                if (ext_ready) fin = 1'b1;
            end
            ST_HOLD: begin
                if (!hold_req) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase
        if (fin) begin
            seq_d.st   = ST_IDLE;
            seq_d.done = 1'b1;
            if (!seq_q.wr) seq_d.rdata = ext_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign act_o     = (seq_q.st == ST_BASE) || (seq_q.st == ST_SWAIT) ||
                       (seq_q.st == ST_XWAIT);
    assign sp_o      = seq_q.sp;
    assign wr_o      = seq_q.wr;
    assign addr_o    = seq_q.addr;
    assign wdata_o   = seq_q.wdata;
    assign last_ws_o = (seq_q.st == ST_SWAIT) && (seq_q.cnt == ONE) && seq_q.rdy_en;
    assign hold_o    = (seq_q.st == ST_HOLD);
    assign done_o    = seq_q.done;
    assign rdata_o   = seq_q.rdata;

    // External stretching only reachable when ready detection is enabled
    assert_xwait_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_XWAIT) |-> seq_q.rdy_en);

    // Hold entered only from idle
    assert_hold_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == ST_HOLD) && ($past(seq_q.st) != ST_HOLD)) |-> ($past(seq_q.st) == ST_IDLE));

    // Completion pulse follows a bus cycle
    assert_done_after_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> $past(act_o));

endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl #(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int WSW    = 3,
    parameter int WS_RST = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [1:0]     req_space,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           done,
    output logic [DW-1:0]  rdata,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_space,
    input  logic [WSW-1:0] cfg_ws,
    output logic           sel_prog_n,
    output logic           sel_data_n,
    output logic           sel_io_n,
    output logic           mem_stb_n,
    output logic           io_stb_n,
    output logic           rw_n,
    output logic [AW-1:0]  ext_addr,
    output logic [DW-1:0]  ext_dout,
    input  logic [DW-1:0]  ext_din,
    output logic           data_oe,
    input  logic           ext_ready,
    output logic           ws_last_n,
    input  logic           hold_req,
    output logic           hold_ack_n,
    input  logic           out_en_n,
    output logic           bus_oe,
    output logic           misc_oe
);
    logic [WSW-1:0] lk_ws;
    logic           act, wr, last_ws, hold;
    logic [1:0]     sp;

    xbus_wscfg #(.WSW(WSW), .WS_RST(WS_RST)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_space (cfg_space),
        .cfg_ws    (cfg_ws),
        .lk_space  (req_space),
        .lk_ws     (lk_ws)
    );

    xbus_seq #(.AW(AW), .DW(DW), .WSW(WSW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_space (req_space),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ws    (lk_ws),
        .ext_ready (ext_ready),
        .hold_req  (hold_req),
        .ext_din   (ext_din),
        .act_o     (act),
        .sp_o      (sp),
        .wr_o      (wr),
        .addr_o    (ext_addr),
        .wdata_o   (ext_dout),
        .last_ws_o (last_ws),
        .hold_o    (hold),
        .done_o    (done),
        .rdata_o   (rdata)
    );

    assign sel_prog_n = !(act && (sp == 2'd0));
    assign sel_data_n = !(act && (sp == 2'd1));
    assign sel_io_n   = !(act && (sp == 2'd2));
    assign mem_stb_n  = !(act && (sp != 2'd2));
    assign io_stb_n   = !(act && (sp == 2'd2));
    assign rw_n       = !(act && wr);
    assign ws_last_n  = !last_ws;
    assign hold_ack_n = !hold;
    assign bus_oe     = out_en_n && !hold;
    assign data_oe    = bus_oe && act && wr;
    assign misc_oe    = out_en_n;

    assert_one_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~sel_prog_n, ~sel_data_n, ~sel_io_n}) <= 1);

    assert_stb_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_stb_n && !io_stb_n));

    assert_write_in_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_n |-> (!mem_stb_n || !io_stb_n));

    assert_wslast_in_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ws_last_n |-> (!mem_stb_n || !io_stb_n));

    assert_hold_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_ack_n |-> (!bus_oe && mem_stb_n && io_stb_n));

endmodule

// File: tb/tb_xbus_wait_ctrl.sv
module tb_xbus_wait_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_space = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_space = '0;
    logic [2:0]  cfg_ws = '0;
    logic        sel_prog_n, sel_data_n, sel_io_n, mem_stb_n, io_stb_n, rw_n;
    logic [15:0] ext_addr, ext_dout;
    logic [15:0] ext_din = '0;
    logic        data_oe, ext_ready, ws_last_n, hold_ack_n, bus_oe, misc_oe;
    logic        hold_req = 1'b0;
    logic        out_en_n = 1'b1;

    logic        rdy_drv = 1'b1;
    logic        fb_mode = 1'b0;
    int          cur_ready_at = 0;
    int          act = 0;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    assign ext_ready = fb_mode ? ws_last_n : rdy_drv;

    always #10 clk = ~clk;

    xbus_wait_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata), .cfg_we(cfg_we), .cfg_space(cfg_space),
        .cfg_ws(cfg_ws), .sel_prog_n(sel_prog_n), .sel_data_n(sel_data_n),
        .sel_io_n(sel_io_n), .mem_stb_n(mem_stb_n), .io_stb_n(io_stb_n),
        .rw_n(rw_n), .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din),
        .data_oe(data_oe), .ext_ready(ext_ready), .ws_last_n(ws_last_n),
        .hold_req(hold_req), .hold_ack_n(hold_ack_n), .out_en_n(out_en_n),
        .bus_oe(bus_oe), .misc_oe(misc_oe)
    );

    typedef struct {
        int          len;
        int          idx;
        int          ws;
        bit          wr;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] rdv;
        string       tag;
    } item_t;

    item_t sb[$];
    item_t e;

    task automatic chk(input bit ok, input string tag, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: per-cycle checks against the head of the scoreboard, pop on done
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_stb_n || !io_stb_n) begin
                act++;
                if (sb.size() > 0) begin
                    e = sb[0];
                    chk({sel_io_n, sel_data_n, sel_prog_n} == (3'b111 & ~(3'b001 << e.idx)),
                        "R1 select", int'({sel_io_n, sel_data_n, sel_prog_n}),
                        int'(3'b111 & ~(3'b001 << e.idx)));
                    chk(ext_addr == e.addr, "R1 address", int'(ext_addr), int'(e.addr));
                    chk({io_stb_n, mem_stb_n} == ((e.idx == 2) ? 2'b01 : 2'b10), "R2 strobe",
                        int'({io_stb_n, mem_stb_n}), (e.idx == 2) ? 1 : 2);
                    chk(rw_n == !e.wr, "R3 rw", int'(rw_n), int'(!e.wr));
                    if (e.wr && out_en_n)
                        chk(data_oe && (ext_dout == e.wdata), "R3 write data",
                            int'(ext_dout), int'(e.wdata));
                    chk(ws_last_n == !((e.ws >= 2) && (act == e.ws + 1)), "R8 last wait",
                        int'(ws_last_n), int'(!((e.ws >= 2) && (act == e.ws + 1))));
                    chk(hold_ack_n == 1'b1, "R9 no hold during access", int'(hold_ack_n), 1);
                end
            end
            rdy_drv <= (act >= cur_ready_at);
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R4 unexpected done", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk(act == e.len, {e.tag, " length"}, act, e.len);
                    if (!e.wr) chk(rdata == e.rdv, "R4 read data", int'(rdata), int'(e.rdv));
                end
                act = 0;
            end
        end
    end

    task automatic cfg(input logic [1:0] sp, input logic [2:0] ws);
        @(negedge clk);
        cfg_we = 1'b1; cfg_space = sp; cfg_ws = ws;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_access(input logic [1:0] sp, input bit wr, input logic [15:0] addr,
                             input logic [15:0] wd, input logic [15:0] rdv, input int ws,
                             input int ready_at, input bit fb, input bit hold_mid,
                             input string tag);
        item_t it;
        it.len = 1 + ws;
        if (ws >= 2) begin
            if (fb) it.len = ws + 2;
            else if (ready_at > ws + 1) it.len = ready_at;
        end
        it.idx = sp[1] ? 2 : int'(sp[0]);
        it.ws = ws; it.wr = wr; it.addr = addr; it.wdata = wd; it.rdv = rdv; it.tag = tag;
        @(negedge clk);
        sb.push_back(it);
        cur_ready_at = ready_at;
        fb_mode = fb;
        ext_din = rdv;
        req_space = sp; req_write = wr; req_addr = addr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        if (hold_mid) hold_req = 1'b1;
        while (!done) @(negedge clk);
        req_valid = 1'b0;
        fb_mode = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset / idle state
        chk({sel_prog_n, sel_data_n, sel_io_n} == 3'b111, "R1 idle selects",
            int'({sel_prog_n, sel_data_n, sel_io_n}), 7);
        chk(mem_stb_n && io_stb_n, "R2 idle strobes", int'({mem_stb_n, io_stb_n}), 3);
        chk(rw_n && !data_oe, "R3 idle rw", int'(rw_n), 1);
        chk(hold_ack_n && ws_last_n && !done, "R9 idle ack", int'(hold_ack_n), 1);
        chk(bus_oe && misc_oe, "R10 idle enables", int'({bus_oe, misc_oe}), 3);

        // Reset counts are 7
        do_access(2'd0, 1'b0, 16'h1234, 16'h0, 16'hA5A5, 7, 0, 1'b0, 1'b0, "R5 reset count");
        do_access(2'd1, 1'b0, 16'h2000, 16'h0, 16'h0F0F, 7, 12, 1'b0, 1'b0, "R7 stretch");

        cfg(2'd0, 3'd0);
        cfg(2'd1, 3'd1);
        cfg(2'd2, 3'd2);
        do_access(2'd0, 1'b0, 16'h0040, 16'h0, 16'h1111, 0, 5, 1'b0, 1'b0, "R6 zero waits");
        do_access(2'd1, 1'b1, 16'h0080, 16'hBEEF, 16'h0, 1, 9, 1'b0, 1'b0, "R6 one wait");
        do_access(2'd2, 1'b0, 16'h00C0, 16'h0, 16'h2222, 2, 0, 1'b0, 1'b0, "R4 two waits");
        do_access(2'd2, 1'b1, 16'h00C4, 16'hC0DE, 16'h0, 2, 6, 1'b0, 1'b0, "R7 io stretch");

        cfg(2'd3, 3'd3);
        do_access(2'd3, 1'b0, 16'h0100, 16'h0, 16'h3333, 3, 0, 1'b1, 1'b0, "R8 feedback");
        do_access(2'd1, 1'b0, 16'h0104, 16'h0, 16'h4444, 1, 0, 1'b1, 1'b0, "R8 feedback one wait");

        // Hold granted from idle, with a request pending
        @(negedge clk);
        hold_req = 1'b1;
        req_valid = 1'b1; req_space = 2'd0; req_write = 1'b0;
        @(negedge clk);
        chk(!hold_ack_n && !bus_oe && misc_oe, "R9 hold granted",
            int'({hold_ack_n, bus_oe}), 0);
        @(negedge clk);
        chk(mem_stb_n && io_stb_n && !data_oe, "R9 no access in hold",
            int'({mem_stb_n, io_stb_n}), 3);
        hold_req = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk(hold_ack_n && bus_oe, "R9 hold released", int'({hold_ack_n, bus_oe}), 3);

        // Hold raised mid-access waits for completion
        cfg(2'd0, 3'd4);
        do_access(2'd0, 1'b0, 16'h0200, 16'h0, 16'h5555, 4, 0, 1'b0, 1'b1, "R9 hold mid access");
        @(negedge clk);
        chk(!hold_ack_n && !bus_oe, "R9 hold after access", int'({hold_ack_n, bus_oe}), 0);
        hold_req = 1'b0;
        @(negedge clk);
        chk(hold_ack_n && bus_oe, "R9 release after access", int'({hold_ack_n, bus_oe}), 3);

        // Global output disable
        out_en_n = 1'b0;
        @(negedge clk);
        chk(!bus_oe && !misc_oe && !data_oe, "R10 disable idle",
            int'({bus_oe, misc_oe, data_oe}), 0);
        do_access(2'd1, 1'b1, 16'h0300, 16'h7777, 16'h0, 1, 0, 1'b0, 1'b0, "R10 access while off");
        chk(!bus_oe && !misc_oe && !data_oe, "R10 disable after write",
            int'({bus_oe, misc_oe, data_oe}), 0);
        out_en_n = 1'b1;
        @(negedge clk);
        chk(bus_oe && misc_oe, "R10 enable restored", int'({bus_oe, misc_oe}), 3);

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
        summary();
    end

endmodule